// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Controller

This block is the digital core of a two-channel 12-bit digital-to-analog converter. An external controller writes 16-bit command words to it over a three-wire serial slave port: an active-low select, a serial clock and a data input. The block oversamples those pins with a fast system clock and assembles each word. When the select line is released, the block decodes the word. It updates a pair of registers for each channel. The first register holds a staged code and the second drives the converter. It also updates per-channel sleep flags, a general-purpose output pin and the launch edge of the serial output.

The serial output is the last stage of the input shift register, so several devices can be chained. A lockout input blocks every sleep request. When the lockout input falls, any sleeping channel wakes up. An active-low clear input returns every register to zero. The 12-bit output codes and the sleep flags go to the analog section, which is not part of this block.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both output codes are 0, both sleep flags are 0, the general-purpose pin is 0 and the serial output is 0.
- R2: A frame is 16 bits, most significant first: a 3-bit opcode, then 12 data bits, then one zero filler bit. Data is taken on rising serial-clock edges while select is low. Opcode 001 writes the staged register of channel A and opcode 101 writes that of channel B. Neither one changes an output code.
- R3: Opcode 011 writes the data to staged A and to output A, and copies staged B to output B. Opcode 111 writes the data to staged B and to output B, and copies staged A to output A.
- R4: Opcode 110 writes the data to both output registers and leaves both staged registers unchanged.
- R5: Opcode 100 copies each staged register into its output register. With opcode 000, the top three data bits select a sub-command: 001 copies channel A only and 101 copies channel B only.
- R6: Opcode 010 sets both sleep flags. Opcode 000 with sub-command 110 sets the A flag only, and with sub-command 111 sets the B flag only. Output codes are kept while a channel sleeps.
- R7: While the lockout input is low, every sleep request is ignored. A falling lockout input clears both sleep flags and leaves the output codes unchanged.
- R8: Any command that writes a channel's output register clears that channel's sleep flag.
- R9: Opcode 000 with sub-command 010 drives the general-purpose pin low. Sub-command 011 drives it high.
- R10: Opcode 000 with the top four data bits 1001 selects rising-edge launch of the serial output, and 1000 selects falling-edge launch. In rising-edge launch, the first bit of a frame appears on the serial output right after the 16th rising edge. In falling-edge launch, it appears after the 16th falling edge.
- R11: A frame that ends after any bit count other than 16 changes nothing. Serial-clock edges while select is high are ignored.
- R12: A low clear input zeroes all staged and output registers, drives the general-purpose pin low and selects falling-edge launch.
- R13: Opcode 000 with sub-command 000 changes no output code, no flag and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| clr_n | input | 1 | Active-low register clear |
| lock_n | input | 1 | Sleep lockout, active low |
| code_a | output | 12 | Output register of channel A |
| code_b | output | 12 | Output register of channel B |
| sleep_a | output | 1 | Channel A sleep flag |
| sleep_b | output | 1 | Channel B sleep flag |
| gp_out | output | 1 | General-purpose output pin |
| dout | output | 1 | Serial data out for chaining |

## Verification
The launch-edge behaviour of the serial output is the hardest case to reach from the ports. It only shows during the narrow interval between the 16th rising edge and the 16th falling edge of a frame, and it depends on the last bit of the previous frame. The stimulus first selects a mode with its own frame. It then sends a frame whose first bit is one and holds the serial clock high after the 16th rising edge. The output is sampled there and again after the final falling edge, before select is released. Malformed frames that are too short or too long, and a lockout fall during sleep, are also driven directly at the pins.

// File: rtl/dacc_pkg.sv
// Package: opcode, sub-command and decoded control types shared by the
// dual-channel DAC command controller. Assumes a 3-bit opcode and a 3-bit
// sub-command field, as fixed by the serial frame layout.
package dacc_pkg;

    typedef enum logic [2:0] {
        OP_SUB         = 3'b000,
        OP_LOAD_A      = 3'b001,
        OP_SLEEP_ALL   = 3'b010,
        OP_LOAD_A_PUSH = 3'b011,
        OP_COPY_ALL    = 3'b100,
        OP_LOAD_B      = 3'b101,
        OP_DIRECT      = 3'b110,
        OP_LOAD_B_PUSH = 3'b111
    } op_e;

    typedef enum logic [2:0] {
        SUB_NOP     = 3'b000,
        SUB_PUSH_A  = 3'b001,
        SUB_GP_LO   = 3'b010,
        SUB_GP_HI   = 3'b011,
        SUB_MODE    = 3'b100,
        SUB_PUSH_B  = 3'b101,
        SUB_SLEEP_A = 3'b110,
        SUB_SLEEP_B = 3'b111
    } sub_e;

    typedef struct packed {
        logic load_a;
        logic load_b;
        logic push_a;
        logic push_b;
        logic direct;
        logic sleep_a;
        logic sleep_b;
        logic gp_wr;
        logic gp_val;
        logic mode_wr;
        logic mode_val;
    } ctl_t;

endpackage

// File: rtl/dacc_sync.sv
// Module: multi-bit two-or-more stage synchronizer. Each bit is independent,
// so it is meant only for slow single-bit controls, not for data buses.
// Assumes a synchronous active-low reset that loads RST_VAL into every stage.
module dacc_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dacc_shifter.sv
// Module: serial frame receiver. It finds the edges of the synchronized serial
// clock and select, shifts data in on rising clock edges while select is low,
// and counts bits (saturating). When select rises it emits a one-cycle
// command strobe, but only if exactly FRAME_W bits arrived. It also drives the
// chained serial output from the last shift stage, launched on the rising
// edge (rise_mode=1) or the falling edge (rise_mode=0).
// Assumes the inputs are already synchronized to clk.
module dacc_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               din_s,
    input  logic               rise_mode,
    output logic               cmd_valid,
    output logic [FRAME_W-1:0] cmd_word,
    output logic               dout
);

    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   bits_q;
    logic               cs_prev_q;
    logic               sclk_prev_q;
    logic               dout_fall_q;
    logic               cs_rise;
    logic               sclk_rise;
    logic               sclk_fall;

    assign cs_rise   =  cs_n_s & ~cs_prev_q;
    assign sclk_rise =  sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s &  sclk_prev_q;

    // Edge-detection history of the synchronized select and clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            cs_prev_q   <= cs_n_s;
            sclk_prev_q <= sclk_s;
        end
    end

    // Shift register and saturating bit counter; the counter clears while select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bits_q  <= '0;
        end else if (cs_n_s) begin
            bits_q <= '0;
        end else if (sclk_rise) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], din_s};
            if (bits_q != CNT_MAX) bits_q <= bits_q + 1'b1;
        end
    end

    // Command strobe on select release, qualified by an exact bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= cs_rise && (bits_q == CNT_FULL);
            if (cs_rise) cmd_word <= shreg_q;
        end
    end

    // Falling-edge launch stage for the chained serial output.
    always_ff @(posedge clk) begin
        if (!rst_n)                   dout_fall_q <= 1'b0;
        else if (!cs_n_s && sclk_fall) dout_fall_q <= shreg_q[FRAME_W-1];
    end

    assign dout = rise_mode ? shreg_q[FRAME_W-1] : dout_fall_q;

endmodule

// File: rtl/dacc_decode.sv
// Module: combinational command decoder. It turns a received frame into
// control strobes. The three top bits are the opcode. When the opcode is zero,
// the top three data bits pick a sub-command and the next bit selects the
// serial-output launch edge. Assumes FRAME_W = DATA_W + 4.
module dacc_decode
    import dacc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W+3:0] word,
    output ctl_t              ctl
);

    localparam int FRAME_W = DATA_W + 4;

    op_e  op;
    sub_e sub;
    logic sub_lsb;

    assign op      = op_e'(word[FRAME_W-1 -: 3]);
    assign sub     = sub_e'(word[DATA_W -: 3]);
    assign sub_lsb = word[DATA_W-3];

    // Map opcode and sub-command to control strobes.
    always_comb begin
        ctl = '0;
        unique case (op)
            OP_LOAD_A:      ctl.load_a = 1'b1;
            OP_LOAD_B:      ctl.load_b = 1'b1;
            OP_LOAD_A_PUSH: begin
                ctl.load_a = 1'b1;
                ctl.push_a = 1'b1;
                ctl.push_b = 1'b1;
            end
            OP_LOAD_B_PUSH: begin
                ctl.load_b = 1'b1;
                ctl.push_a = 1'b1;
                ctl.push_b = 1'b1;
            end
            OP_DIRECT: begin
                ctl.direct = 1'b1;
                ctl.push_a = 1'b1;
                ctl.push_b = 1'b1;
            end
            OP_COPY_ALL: begin
                ctl.push_a = 1'b1;
                ctl.push_b = 1'b1;
            end
            OP_SLEEP_ALL: begin
                ctl.sleep_a = 1'b1;
                ctl.sleep_b = 1'b1;
            end
            OP_SUB: begin
                unique case (sub)
                    SUB_PUSH_A:  ctl.push_a  = 1'b1;
                    SUB_PUSH_B:  ctl.push_b  = 1'b1;
                    SUB_SLEEP_A: ctl.sleep_a = 1'b1;
                    SUB_SLEEP_B: ctl.sleep_b = 1'b1;
                    SUB_GP_LO: begin
                        ctl.gp_wr  = 1'b1;
                        ctl.gp_val = 1'b0;
                    end
                    SUB_GP_HI: begin
                        ctl.gp_wr  = 1'b1;
                        ctl.gp_val = 1'b1;
                    end
                    SUB_MODE: begin
                        ctl.mode_wr  = 1'b1;
                        ctl.mode_val = sub_lsb;
                    end
                    default: ctl = '0;
                endcase
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/dacc_regfile.sv
// Module: per-channel staged and output registers, sleep flags, general-purpose
// pin and launch-mode bit. Commands apply on the cycle cmd_valid is high.
// A low synchronized clear acts like reset. A low synchronized lockout blocks
// sleep requests and forces both flags clear, so the fall of lockout wakes
// both channels. Assumes the inputs are synchronized to clk.
module dacc_regfile
    import dacc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n_s,
    input  logic              lock_n_s,
    input  logic              cmd_valid,
    input  logic [DATA_W+3:0] cmd_word,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              sleep_a,
    output logic              sleep_b,
    output logic              gp_out,
    output logic              rise_mode
);

    ctl_t              ctl;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] stage_a_q;
    logic [DATA_W-1:0] stage_b_q;
    logic              wipe;

    assign data = cmd_word[DATA_W:1];
    assign wipe = !rst_n || !clr_n_s;

    dacc_decode #(.DATA_W(DATA_W)) u_decode (
        .word (cmd_word),
        .ctl  (ctl)
    );

    // Staged registers: loaded from the frame data.
    always_ff @(posedge clk) begin
        if (wipe) begin
            stage_a_q <= '0;
            stage_b_q <= '0;
        end else if (cmd_valid) begin
            if (ctl.load_a) stage_a_q <= data;
            if (ctl.load_b) stage_b_q <= data;
        end
    end

    // Output registers: take frame data when it is loaded or direct, otherwise the staged value.
    always_ff @(posedge clk) begin
        if (wipe) begin
            code_a <= '0;
            code_b <= '0;
        end else if (cmd_valid) begin
            if (ctl.push_a) code_a <= (ctl.direct || ctl.load_a) ? data : stage_a_q;
            if (ctl.push_b) code_b <= (ctl.direct || ctl.load_b) ? data : stage_b_q;
        end
    end

    // Sleep flags: lockout clears, an output update clears, a sleep request sets.
    always_ff @(posedge clk) begin
        if (wipe || !lock_n_s) begin
            sleep_a <= 1'b0;
            sleep_b <= 1'b0;
        end else if (cmd_valid) begin
            if (ctl.push_a)       sleep_a <= 1'b0;
            else if (ctl.sleep_a) sleep_a <= 1'b1;
            if (ctl.push_b)       sleep_b <= 1'b0;
            else if (ctl.sleep_b) sleep_b <= 1'b1;
        end
    end

    // General-purpose pin and serial-output launch mode.
    always_ff @(posedge clk) begin
        if (wipe) begin
            gp_out    <= 1'b0;
            rise_mode <= 1'b0;
        end else if (cmd_valid) begin
            if (ctl.gp_wr)   gp_out    <= ctl.gp_val;
            if (ctl.mode_wr) rise_mode <= ctl.mode_val;
        end
    end

endmodule

// File: rtl/dual_dac_ctrl.sv
// Module: top of the dual-channel DAC serial command controller. It
// synchronizes the five slow pins, receives frames and applies the commands
// to the register file. Assumes clk is at least several times faster than
// the serial clock, so that each serial-clock phase spans a few system cycles.
module dual_dac_ctrl #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              clr_n,
    input  logic              lock_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              sleep_a,
    output logic              sleep_b,
    output logic              gp_out,
    output logic              dout
);

    localparam int FRAME_W = DATA_W + 4;

    logic [4:0]         pins_s;
    logic               cs_n_s;
    logic               sclk_s;
    logic               din_s;
    logic               clr_n_s;
    logic               lock_n_s;
    logic               cmd_valid;
    logic [FRAME_W-1:0] cmd_word;
    logic               rise_mode;

    dacc_sync #(
        .WIDTH   (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b11001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_n, clr_n, lock_n, sclk, din}),
        .q_sync  (pins_s)
    );

    assign {cs_n_s, clr_n_s, lock_n_s, sclk_s, din_s} = pins_s;

    dacc_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .rise_mode (rise_mode),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .dout      (dout)
    );

    dacc_regfile #(.DATA_W(DATA_W)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n_s   (clr_n_s),
        .lock_n_s  (lock_n_s),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .code_a    (code_a),
        .code_b    (code_b),
        .sleep_a   (sleep_a),
        .sleep_b   (sleep_b),
        .gp_out    (gp_out),
        .rise_mode (rise_mode)
    );

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
// Module: assertion checker bound to dual_dac_ctrl. It relates the receiver's
// command strobe and the synchronized clear and lockout to the register
// outputs on the next cycle.
module dual_dac_ctrl_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n_s,
    input logic              lock_n_s,
    input logic              cmd_valid,
    input logic [DATA_W+3:0] cmd_word,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              sleep_a,
    input logic              sleep_b,
    input logic              gp_out
);

    localparam int FRAME_W = DATA_W + 4;

    logic [2:0] op;
    assign op = cmd_word[FRAME_W-1 -: 3];

    assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && clr_n_s && op == 3'b110
        |=> code_a == $past(cmd_word[DATA_W:1]) && code_b == $past(cmd_word[DATA_W:1]));

    assert_sleep_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && clr_n_s && lock_n_s && op == 3'b010 |=> sleep_a && sleep_b);

    assert_lockout_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n_s |=> !sleep_a && !sleep_b);

    assert_copy_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == 3'b100 |=> !sleep_a && !sleep_b);

    assert_gp_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && clr_n_s && cmd_word[FRAME_W-1 -: 7] == 7'b0000110 |=> gp_out);

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> code_a == '0 && code_b == '0 && !gp_out);

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid && clr_n_s |=> $stable(code_a) && $stable(code_b) && $stable(gp_out));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n_s   (clr_n_s),
    .lock_n_s  (lock_n_s),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .code_a    (code_a),
    .code_b    (code_b),
    .sleep_a   (sleep_a),
    .sleep_b   (sleep_b),
    .gp_out    (gp_out)
);

// File: tb/dual_dac_ctrl_bench.sv
// Directed bench for dual_dac_ctrl: one task per scenario, each checking its own results.
module dual_dac_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        clr_n = 1'b1;
    logic        lock_n = 1'b1;
    logic [11:0] code_a;
    logic [11:0] code_b;
    logic        sleep_a;
    logic        sleep_b;
    logic        gp_out;
    logic        dout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_dac_ctrl u_dual_dac_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .din     (din),
        .clr_n   (clr_n),
        .lock_n  (lock_n),
        .code_a  (code_a),
        .code_b  (code_b),
        .sleep_a (sleep_a),
        .sleep_b (sleep_b),
        .gp_out  (gp_out),
        .dout    (dout)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_codes(input string req, input int ea, input int eb);
        check(req, "code_a", int'(code_a), ea);
        check(req, "code_b", int'(code_b), eb);
    endtask

    task automatic check_sleep(input string req, input int ea, input int eb);
        check(req, "sleep_a", int'(sleep_a), ea);
        check(req, "sleep_b", int'(sleep_b), eb);
    endtask

    function automatic logic [15:0] mk(input logic [2:0] op, input logic [11:0] data);
        return {op, data, 1'b0};
    endfunction

    function automatic logic [15:0] mks(input logic [3:0] sub);
        return {3'b000, sub, 8'h00, 1'b0};
    endfunction

    // Drive n bits; when open is set, stop with the last clock high and select low.
    task automatic send_bits(input logic [15:0] w, input int n, input bit open);
        cs_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < n; i++) begin
            din = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(8);
            if (open && i == n - 1) return;
            sclk = 1'b0;
            wait_clk(4);
        end
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic send(input logic [15:0] w);
        send_bits(w, 16, 1'b0);
    endtask

    // Serial-output probe around the 16th edges of a frame that starts with 1 (R10).
    task automatic probe_dout(input string req, input int at_rise);
        send_bits(mk(3'b100, 12'h5A5), 16, 1'b1);
        check(req, "dout after 16th rise", int'(dout), at_rise);
        sclk = 1'b0;
        wait_clk(8);
        check(req, "dout after 16th fall", int'(dout), 1);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic t_reset;
        check_codes("R1", 0, 0);
        check_sleep("R1", 0, 0);
        check("R1", "gp_out", int'(gp_out), 0);
        check("R1", "dout", int'(dout), 0);
    endtask

    task automatic t_load_input;
        send(mk(3'b001, 12'h123));
        send(mk(3'b101, 12'h456));
        check_codes("R2", 0, 0);
        send(mk(3'b100, 12'h000));
        check_codes("R5", 'h123, 'h456);
    endtask

    task automatic t_load_update;
        send(mk(3'b011, 12'hABC));
        check_codes("R3", 'hABC, 'h456);
        send(mk(3'b111, 12'h0F0));
        check_codes("R3", 'hABC, 'h0F0);
    endtask

    task automatic t_direct;
        send(mk(3'b110, 12'h777));
        check_codes("R4", 'h777, 'h777);
        send(mk(3'b100, 12'h000));
        check_codes("R4", 'hABC, 'h0F0);
    endtask

    task automatic t_single;
        send(mk(3'b001, 12'h111));
        send(mks(4'b0010));
        check_codes("R5", 'h111, 'h0F0);
        send(mk(3'b101, 12'h222));
        send(mks(4'b1010));
        check_codes("R5", 'h111, 'h222);
    endtask

    task automatic t_sleep;
        send(mk(3'b010, 12'hFFF));
        check_sleep("R6", 1, 1);
        check_codes("R6", 'h111, 'h222);
        send(mks(4'b0010));
        check_sleep("R8", 0, 1);
        send(mks(4'b1100));
        check_sleep("R6", 1, 1);
        send(mk(3'b100, 12'h000));
        check_sleep("R8", 0, 0);
        send(mks(4'b1110));
        check_sleep("R6", 0, 1);
        send(mk(3'b110, 12'h333));
        check_sleep("R8", 0, 0);
        send(mk(3'b100, 12'h000));
        check_codes("R8", 'h111, 'h222);
    endtask

    task automatic t_lockout;
        lock_n = 1'b0;
        wait_clk(8);
        send(mk(3'b010, 12'h000));
        check_sleep("R7", 0, 0);
        send(mks(4'b1100));
        check_sleep("R7", 0, 0);
        lock_n = 1'b1;
        wait_clk(8);
        send(mk(3'b010, 12'h000));
        check_sleep("R7", 1, 1);
        lock_n = 1'b0;
        wait_clk(8);
        check_sleep("R7", 0, 0);
        check_codes("R7", 'h111, 'h222);
        lock_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic t_gp;
        send(mks(4'b0110));
        check("R9", "gp_out high", int'(gp_out), 1);
        send(mks(4'b0100));
        check("R9", "gp_out low", int'(gp_out), 0);
        send(mks(4'b0110));
    endtask

    task automatic t_nop;
        send({3'b000, 4'b0001, 8'hFF, 1'b0});
        check_codes("R13", 'h111, 'h222);
        check("R13", "gp_out", int'(gp_out), 1);
        check_sleep("R13", 0, 0);
    endtask

    task automatic t_partial;
        send_bits(mk(3'b110, 12'h999), 15, 1'b0);
        check_codes("R11 short", 'h111, 'h222);
        send_bits(mk(3'b110, 12'h999), 17, 1'b0);
        check_codes("R11 long", 'h111, 'h222);
        for (int i = 0; i < 5; i++) begin
            din = 1'b1;
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
            wait_clk(8);
        end
        check_codes("R11 idle", 'h111, 'h222);
        send(mk(3'b110, 12'h345));
        check_codes("R11 after", 'h345, 'h345);
    endtask

    task automatic t_dout;
        send(mks(4'b1001));
        probe_dout("R10 rise", 1);
        send(mks(4'b1000));
        probe_dout("R10 fall", 0);
    endtask

    task automatic t_clear;
        send(mks(4'b1001));
        send(mk(3'b011, 12'h876));
        clr_n = 1'b0;
        wait_clk(8);
        clr_n = 1'b1;
        wait_clk(8);
        check_codes("R12", 0, 0);
        check("R12", "gp_out", int'(gp_out), 0);
        probe_dout("R12 mode", 0);
        check_codes("R12 staged", 0, 0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_load_input();
        t_load_update();
        t_direct();
        t_single();
        t_sleep();
        t_lockout();
        t_gp();
        t_nop();
        t_partial();
        t_dout();
        t_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule